// File: doc/BRIEF.md
# Fast Ethernet PCS Receive Framer

This block sits between the clock-recovery and NRZI-decoding stage and a nibble-wide MAC-side interface of a 100 Mb/s twisted-pair receiver. It accepts the recovered, unscrambled code-bit stream one bit per enabled clock. In the all-ones idle line it looks for the pattern that opens a stream, and it confirms the idle/J/K start delimiter. That delimiter fixes where each 5-bit code group begins. The block then hands every following code group to the MAC side. It reports line errors and drops carrier when the stream ends.

A stream ends in one of two ways. A proper end is a T group followed by an R group; neither group is forwarded. A premature end is two idle groups in a row; this pulses the error output and sets a flag that stays set until a status read strobe clears it. The receiving flag is produced by the receive state machine. Carrier sense is a separate registered state machine that follows that flag one cycle later.

Top module: `pcs_rx_framer`

## Requirements
- R1: A lone zero bit, or a run of adjacent zero bits, followed only by ones within the arm window of ARM_BITS bits after the first zero, never raises `receiving` or `crs`.
- R2: In idle, a first zero bit followed later in the arm window by another zero bit with at least one one bit between them sets `receiving` on the clock edge that samples the second zero.
- R3: `crs` rises exactly one clock after `receiving` rises.
- R4: When carrier is detected and the 15 bits ending three bits later are not idle 11111, J 11000, K 10001 (oldest bit first), `rx_er` pulses once, `receiving` clears, and no group is forwarded.
- R5: `crs` falls one clock after `receiving` falls and stays low while `receiving` is low.
- R6: After a confirmed start delimiter, each later 5-bit group is output on `rx_code` with a one-cycle `rx_dv` pulse. The first received bit of the group is bit 4.
- R7: A T group (01101) followed directly by an R group (00111) ends reception with no `rx_dv` and no `rx_er` for either group.
- R8: A forwarded group that is not one of the 16 data code groups, or that directly follows a T, or a lone R or lone idle group, is forwarded with `rx_er` in the same cycle. Reception then continues.
- R9: A second idle group (11111) directly after an idle group, during reception, pulses `rx_er` without `rx_dv`, clears `receiving`, and sets `prem_stat`.
- R10: `prem_stat` holds until a cycle with `stat_rd` high clears it; a premature end reported in the same cycle as the read leaves it set.
- R11: While and just after `rst`, `receiving`, `crs`, `rx_dv`, `rx_er` and `prem_stat` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A code bit is present on `bit_in` this cycle |
| bit_in | input | 1 | NRZI-decoded code bit, oldest first |
| stat_rd | input | 1 | Status read strobe, clears `prem_stat` |
| receiving | output | 1 | Receive state machine holds carrier |
| crs | output | 1 | Carrier sense toward the MAC |
| rx_dv | output | 1 | One-cycle strobe for `rx_code` |
| rx_code | output | 5 | Forwarded code group, bit 4 received first |
| rx_er | output | 1 | One-cycle receive error strobe |
| prem_stat | output | 1 | Sticky premature-end flag |

## Verification
The same idle/J/K-framed stream is sent several ways:
- With only valid data groups.
- With an invalid group, a lone R, or a lone idle in the middle. These show that code errors are flagged but do not end reception.
- With a T followed by a data group before the real T/R.
- Ending in two idles instead of T/R, which tells a premature end apart from a proper one.

A corrupted K group shows that carrier detection and delimiter confirmation are separate steps. Idle-line noise tells apart adjacent zeros, which must be ignored, from zeros separated by a one, which must arm the receiver. A bit-by-bit run fixes the exact edges at which `receiving` and `crs` rise. A read strobe timed against a premature end confirms that a new premature end wins over the read.

// File: rtl/pcs_rx_pkg.sv
`timescale 1ns/1ps
package pcs_rx_pkg;

  localparam int GW = 5;

  typedef logic [GW-1:0] cgrp_t;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_ARM,
    RS_CARR,
    RS_RECV
  } rx_state_e;

  typedef enum logic {
    CS_OFF,
    CS_ON
  } cs_state_e;

  localparam cgrp_t CG_I = 5'b11111;
  localparam cgrp_t CG_J = 5'b11000;
  localparam cgrp_t CG_K = 5'b10001;
  localparam cgrp_t CG_T = 5'b01101;
  localparam cgrp_t CG_R = 5'b00111;

  // true for the sixteen code groups that carry a data nibble
  function automatic logic is_data(input cgrp_t c);
    case (c)
      5'b11110, 5'b01001, 5'b10100, 5'b10101,
      5'b01010, 5'b01011, 5'b01110, 5'b01111,
      5'b10010, 5'b10011, 5'b10110, 5'b10111,
      5'b11010, 5'b11011, 5'b11100, 5'b11101: is_data = 1'b1;
      default:                                is_data = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pcs_rx_hist.sv
`timescale 1ns/1ps
module pcs_rx_hist #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_vld,
  input  logic         bit_in,
  output logic [W-1:0] win
);

  logic [W-2:0] hist;

  // newest bit sits at the LSB; the line rests at all ones
  assign win = {hist, bit_in};

  always_ff @(posedge clk) begin
    if (rst)          hist <= '1;
    else if (bit_vld) hist <= win[W-2:0];
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> win[1] == $past(bit_in)); // R6

endmodule

// File: rtl/pcs_rx_fsm.sv
`timescale 1ns/1ps
module pcs_rx_fsm
  import pcs_rx_pkg::*;
#(
  parameter int ARM_BITS = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_vld,
  input  logic [3*GW-1:0] win,
  output logic            receiving,
  output logic            rx_dv,
  output cgrp_t           rx_code,
  output logic            rx_er,
  output logic            prem_evt
);

  localparam int ACW = (ARM_BITS > 1) ? $clog2(ARM_BITS) : 1;
  localparam int CONF_BITS = GW - 2;
  localparam int WCW = $clog2(CONF_BITS);
  localparam int GCW = $clog2(GW);
  localparam logic [ACW-1:0] ARM_LAST  = ACW'(ARM_BITS - 1);
  localparam logic [WCW-1:0] CONF_LAST = WCW'(CONF_BITS - 1);
  localparam logic [GCW-1:0] GRP_LAST  = GCW'(GW - 1);
  localparam logic [3*GW-1:0] SSD_PAT  = {CG_I, CG_J, CG_K};

  rx_state_e      state;
  logic [ACW-1:0] arm_cnt;
  logic [WCW-1:0] wait_cnt;
  logic [GCW-1:0] grp_cnt;
  logic           seen_one;
  logic           t_pend;
  logic           i_pend;
  logic           cur_bit;
  cgrp_t          grp;

  assign cur_bit = win[0];
  assign grp     = win[GW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RS_IDLE;
      arm_cnt   <= '0;
      wait_cnt  <= '0;
      grp_cnt   <= '0;
      seen_one  <= 1'b0;
      t_pend    <= 1'b0;
      i_pend    <= 1'b0;
      receiving <= 1'b0;
      rx_dv     <= 1'b0;
      rx_code   <= '0;
      rx_er     <= 1'b0;
      prem_evt  <= 1'b0;
    end else begin
      rx_dv    <= 1'b0;
      rx_er    <= 1'b0;
      prem_evt <= 1'b0;
      if (bit_vld) begin
        unique case (state)
          RS_IDLE: begin
            if (!cur_bit) begin
              state    <= RS_ARM;
              arm_cnt  <= '0;
              seen_one <= 1'b0;
            end
          end
          RS_ARM: begin
            if (!cur_bit && seen_one) begin
              state     <= RS_CARR;
              receiving <= 1'b1;
              wait_cnt  <= '0;
            end else begin
              if (cur_bit) seen_one <= 1'b1;
              if (arm_cnt == ARM_LAST) state   <= RS_IDLE;
              else                     arm_cnt <= arm_cnt + 1'b1;
            end
          end
          RS_CARR: begin
            if (wait_cnt == CONF_LAST) begin
              if (win == SSD_PAT) begin
                state   <= RS_RECV;
                grp_cnt <= '0;
                t_pend  <= 1'b0;
                i_pend  <= 1'b0;
              end else begin
                rx_er     <= 1'b1;
                receiving <= 1'b0;
                state     <= RS_IDLE;
              end
            end else begin
              wait_cnt <= wait_cnt + 1'b1;
            end
          end
          RS_RECV: begin
            if (grp_cnt != GRP_LAST) begin
              grp_cnt <= grp_cnt + 1'b1;
            end else begin
              grp_cnt <= '0;
              if (t_pend) begin
                t_pend <= 1'b0;
                if (grp == CG_R) begin
                  receiving <= 1'b0;
                  state     <= RS_IDLE;
                end else begin
                  rx_dv   <= 1'b1;
                  rx_code <= grp;
                  rx_er   <= 1'b1;
                  i_pend  <= (grp == CG_I);
                end
              end else if (grp == CG_T) begin
                t_pend <= 1'b1;
                i_pend <= 1'b0;
              end else if (grp == CG_I && i_pend) begin
                rx_er     <= 1'b1;
                prem_evt  <= 1'b1;
                receiving <= 1'b0;
                state     <= RS_IDLE;
              end else begin
                rx_dv   <= 1'b1;
                rx_code <= grp;
                rx_er   <= !is_data(grp);
                i_pend  <= (grp == CG_I);
              end
            end
          end
        endcase
      end
    end
  end

  AST_DV_SPACED: assert property (@(posedge clk) disable iff (rst)
    rx_dv |=> !rx_dv); // R6
  AST_DV_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
    rx_dv |-> receiving); // R6
  AST_PREM_ERR: assert property (@(posedge clk) disable iff (rst)
    prem_evt |-> (rx_er && !rx_dv)); // R9
  AST_RX_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bit_vld && !receiving |=> !receiving); // R1

endmodule

// File: rtl/pcs_rx_crs.sv
`timescale 1ns/1ps
module pcs_rx_crs
  import pcs_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic receiving,
  input  logic prem_evt,
  input  logic stat_rd,
  output logic crs,
  output logic prem_stat
);

  cs_state_e cs;

  assign crs = (cs == CS_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs        <= CS_OFF;
      prem_stat <= 1'b0;
    end else begin
      unique case (cs)
        CS_OFF: if (receiving)  cs <= CS_ON;
        CS_ON:  if (!receiving) cs <= CS_OFF;
      endcase
      // a new event outranks a read in the same cycle
      prem_stat <= prem_evt | (prem_stat & ~stat_rd);
    end
  end

  AST_CRS_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(receiving) |=> crs); // R3
  AST_CRS_OFF: assert property (@(posedge clk) disable iff (rst)
    !receiving |=> !crs); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    prem_stat && !stat_rd |=> prem_stat); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    prem_evt |=> prem_stat); // R10

endmodule

// File: rtl/pcs_rx_framer.sv
`timescale 1ns/1ps
module pcs_rx_framer
  import pcs_rx_pkg::*;
#(
  parameter int ARM_BITS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       stat_rd,
  output logic       receiving,
  output logic       crs,
  output logic       rx_dv,
  output logic [4:0] rx_code,
  output logic       rx_er,
  output logic       prem_stat
);

  localparam int WIN_W = 3 * GW;

  logic [WIN_W-1:0] win;
  logic             prem_evt;
  cgrp_t            code_q;

  pcs_rx_hist #(.W(WIN_W)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .win     (win)
  );

  pcs_rx_fsm #(.ARM_BITS(ARM_BITS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .win       (win),
    .receiving (receiving),
    .rx_dv     (rx_dv),
    .rx_code   (code_q),
    .rx_er     (rx_er),
    .prem_evt  (prem_evt)
  );

  assign rx_code = code_q;

  pcs_rx_crs u_crs (
    .clk       (clk),
    .rst       (rst),
    .receiving (receiving),
    .prem_evt  (prem_evt),
    .stat_rd   (stat_rd),
    .crs       (crs),
    .prem_stat (prem_stat)
  );

  AST_DV_UNDER_CRS: assert property (@(posedge clk) disable iff (rst)
    rx_dv |-> crs); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !(receiving || crs || rx_dv || rx_er || prem_stat)); // R11

endmodule

// File: tb/tb_pcs_rx_framer.sv
`timescale 1ns/1ps
module tb_pcs_rx_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b1;
  logic       stat_rd = 1'b0;
  logic       receiving, crs, rx_dv, rx_er, prem_stat;
  logic [4:0] rx_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int         m_dv, m_er;
  bit         m_crs, m_clr;
  logic [4:0] m_codes [16];

  // stimulus: 4 data groups [30:11], end kind [10:9], exp dv [8:5], exp er [4:1], exp sticky [0]
  // kind 0 = T,R   1 = idle,idle   2 = corrupted K   3 = T,data then T,R
  localparam logic [30:0] VEC [7] = '{
    {5'h1E, 5'h09, 5'h0B, 5'h16, 2'd0, 4'd4, 4'd0, 1'b0},
    {5'h1D, 5'h1A, 5'h00, 5'h09, 2'd0, 4'd4, 4'd1, 1'b0},
    {5'h1E, 5'h07, 5'h1E, 5'h1E, 2'd0, 4'd4, 4'd1, 1'b0},
    {5'h16, 5'h16, 5'h0B, 5'h09, 2'd1, 4'd5, 4'd2, 1'b1},
    {5'h09, 5'h09, 5'h09, 5'h09, 2'd3, 4'd5, 4'd1, 1'b0},
    {20'h0,                      2'd2, 4'd0, 4'd1, 1'b0},
    {5'h09, 5'h1F, 5'h09, 5'h0B, 2'd0, 4'd4, 4'd1, 1'b0}
  };

  pcs_rx_framer dut (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .stat_rd   (stat_rd),
    .receiving (receiving),
    .crs       (crs),
    .rx_dv     (rx_dv),
    .rx_code   (rx_code),
    .rx_er     (rx_er),
    .prem_stat (prem_stat)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (m_clr) begin
      m_dv = 0; m_er = 0; m_crs = 1'b0;
    end else begin
      if (rx_dv) begin
        if (m_dv < 16) m_codes[m_dv] = rx_code;
        m_dv++;
      end
      if (rx_er) m_er++;
      if (crs) m_crs = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
  endtask

  task automatic send_grp(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic mon_clear();
    @(negedge clk); bit_in = 1'b1; m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
  endtask

  task automatic read_stat();
    @(negedge clk); bit_in = 1'b1; stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    m_clr = 1'b0; m_dv = 0; m_er = 0; m_crs = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R11: quiet outputs during reset
    chk(!(receiving || crs || rx_dv || rx_er || prem_stat), "R11 in reset", 1, 0);
    @(negedge clk); rst = 1'b0; bit_vld = 1'b1; bit_in = 1'b1;
    @(posedge clk); #1;
    chk(!(receiving || crs || rx_dv || rx_er || prem_stat), "R11 after reset", 1, 0);

    // table walk
    for (int v = 0; v < 7; v++) begin
      logic [30:0] e;
      logic [1:0]  kind;
      e = VEC[v];
      kind = e[10:9];
      read_stat();
      mon_clear();
      send_grp(5'h1F); send_grp(5'h1F); send_grp(5'b11000);
      if (kind == 2'd2) begin
        send_grp(5'b10101);
      end else begin
        send_grp(5'b10001);
        for (int g = 0; g < 4; g++) send_grp(e[30-5*g -: 5]);
        case (kind)
          2'd0: begin send_grp(5'b01101); send_grp(5'b00111); end
          2'd1: begin send_grp(5'h1F); send_grp(5'h1F); end
          default: begin
            send_grp(5'b01101); send_grp(5'h1E);
            send_grp(5'b01101); send_grp(5'b00111);
          end
        endcase
      end
      for (int g = 0; g < 3; g++) send_grp(5'h1F);
      // R6 forwarded count, R4/R8/R9 error count
      chk(m_dv == int'(e[8:5]), "R6 dv count", m_dv, int'(e[8:5]));
      chk(m_er == int'(e[4:1]), "R8 er count", m_er, int'(e[4:1]));
      if (kind != 2'd2) begin
        for (int g = 0; g < 4; g++)
          chk(m_codes[g] == e[30-5*g -: 5], "R6 code", int'(m_codes[g]), int'(e[30-5*g -: 5]));
      end
      chk(prem_stat == e[0], "R9 sticky", int'(prem_stat), int'(e[0]));
      chk(m_crs, "R3 crs seen", int'(m_crs), 1);
      chk(!crs && !receiving, "R5 crs dropped", int'(crs), 0);
    end

    // R1: noise in the idle line
    mon_clear();
    send_bit(1); send_bit(1); send_bit(0);
    for (int i = 0; i < 15; i++) send_bit(1);
    send_bit(0); send_bit(0);
    for (int i = 0; i < 15; i++) send_bit(1);
    chk(!m_crs && m_er == 0, "R1 noise ignored", int'(m_crs), 0);

    // R2 + R4: separated zeros arm, but no J/K follows
    mon_clear();
    send_bit(0); send_bit(1); send_bit(0);
    for (int i = 0; i < 12; i++) send_bit(1);
    chk(m_crs, "R2 carrier on separated zeros", int'(m_crs), 1);
    chk(m_er == 1 && m_dv == 0, "R4 bad delimiter", m_er, 1);

    // R2/R3 edge timing, then R7 clean end
    mon_clear();
    send_grp(5'h1F); send_grp(5'b11000);
    send_bit(1);
    @(posedge clk); #1;
    chk(!receiving, "R2 not yet", int'(receiving), 0);
    send_bit(0);
    @(posedge clk); #1;
    chk(receiving, "R2 receiving rises", int'(receiving), 1);
    chk(!crs, "R3 crs lags", int'(crs), 0);
    send_bit(0);
    @(posedge clk); #1;
    chk(crs, "R3 crs rises", int'(crs), 1);
    send_bit(0); send_bit(1);
    send_grp(5'h09); send_grp(5'b01101); send_grp(5'b00111);
    for (int g = 0; g < 2; g++) send_grp(5'h1F);
    chk(m_dv == 1 && m_codes[0] == 5'h09, "R7 only data forwarded", m_dv, 1);
    chk(m_er == 0 && !receiving, "R7 clean end", m_er, 0);

    // R10: premature end coincident with a read, then a plain read
    read_stat();
    send_grp(5'h1F); send_grp(5'b11000); send_grp(5'b10001);
    send_grp(5'h09); send_grp(5'h1F);
    for (int i = 0; i < 5; i++) send_bit(1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    #1;
    chk(prem_stat, "R10 set wins over read", int'(prem_stat), 1);
    repeat (4) @(negedge clk);
    chk(prem_stat, "R10 holds", int'(prem_stat), 1);
    read_stat();
    #1;
    chk(!prem_stat, "R10 read clears", int'(prem_stat), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule